// File: doc/BRIEF.md
# Page-wide Hamming ECC engine

This block sits beside a NAND flash data bus and watches every data strobe. Over one whole page, spare area included, it builds a single-error-correcting, double-error-detecting Hamming code. The result is 32 bits, kept as two 16-bit halves: a parity word and a complementary parity word. On a program cycle the host reads both halves once the last page word has passed, and stores them as four code bytes.

On a read cycle the stored code bytes follow the page data directly. The engine captures them, forms the syndrome and classifies the page into one of four cases: clean, one correctable data bit, one flipped bit inside the code itself, or more errors than it can correct. For a data error the parity output changes meaning and gives the error location: the bit inside the word on bits [3:0] and the word index on bits [15:4]. A blank page of all-ones data with all-ones code gives a fixed signature, so software can tell it apart from a real failure.

Top module: `ecc_page_engine`

## Requirements
- R1: After reset, par_word, npar_word, st_rec, st_mul, st_code and chk_done are all 0. The mode is a 528-byte span on the 8-bit bus.
- R2: Each accepted data word updates the code. For every set bit at address a = word_index*16 + bit, par_word ^= a and npar_word ^= ~a, both 16 bits wide. On the 8-bit bus only bus_data[7:0] counts, and bus_data[15:8] has no effect.
- R3: The code is four bytes. Bytes 0 and 1 are par_word, low byte first. Bytes 2 and 3 are npar_word, low byte first. On the 8-bit bus each strobe carries one byte on bus_data[7:0]. On the 16-bit bus each strobe carries two bytes, with the lower-numbered byte on bus_data[7:0].
- R4: cmd_clr, or a write of the mode (mode_we), starts an empty page: par_word and npar_word return to 0, all flags drop, and the word count restarts.
- R5: mode_span values 0, 1, 2 and 3 select 528, 1056, 2112 and 4224 bytes. A page holds that many words on the 8-bit bus and half that many on the 16-bit bus (mode_wide=1). Strobes after the last page word are taken as code bytes.
- R6: chk_done rises one clock after the last code strobe is accepted. The results then hold steady until the next page starts.
- R7: If the stored code matches the recomputed code, all flags are 0 and par_word reads 0 while chk_done is high.
- R8: A single flipped data bit sets st_rec only. par_word[3:0] gives the bit offset and par_word[15:4] gives the word index.
- R9: On the 16-bit bus the bit offset covers 0 to 15 within a halfword.
- R10: A syndrome with exactly one set bit sets st_rec and st_code. par_word then shows the syndrome of the parity half.
- R11: Any other nonzero syndrome that is not one data error sets st_rec and st_mul.
- R12: If every data word is all ones and all four code bytes are 0xFF, the result is st_rec=1, st_mul=1 and par_word=16'hFFFF.
- R13: A data strobe while chk_done is high starts a new page. The results clear, and that strobe counts as word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_we | input | 1 | Loads mode_span and mode_wide and clears the page |
| mode_span | input | 2 | Protected span select (528 bytes shifted left by this value) |
| mode_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cmd_clr | input | 1 | Clear command: restarts the page |
| bus_valid | input | 1 | One data strobe on the flash bus |
| bus_data | input | 16 | Data on the flash bus |
| par_word | output | 16 | Parity half; error location while chk_done is high |
| npar_word | output | 16 | Complementary parity half |
| st_rec | output | 1 | Some error was found |
| st_mul | output | 1 | Uncorrectable (multiple) error |
| st_code | output | 1 | The single flipped bit lies in the code bytes |
| chk_done | output | 1 | The check result is valid |

## Verification
The assertions assume three things about the inputs. No strobe arrives in the single compare cycle between the last code byte and chk_done. A clear is never given together with a strobe. The 4224-byte span is never used on the 8-bit bus, where the word index would need more than 12 bits. The stimulus keeps to these limits: it leaves at least one idle cycle after each code sequence, issues clears and mode writes on idle cycles, and runs the largest span only in 16-bit mode. It does send junk on the upper data byte during 8-bit pages, to show that byte has no effect.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_CODE = 2'd1,
    ST_CMP  = 2'd2,
    ST_DONE = 2'd3
  } ecc_state_e;

  typedef struct packed {
    logic rec;
    logic mul;
    logic cod;
  } ecc_flags_t;

  // Bit b of the mask is set when bit k of the index b is set.
  function automatic logic [63:0] col_sel(input int k);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) begin
      r[b] = ((b >> k) & 1) == 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import ecc_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     en,
  input  logic [ROW_W-1:0]         idx,
  input  logic [(1<<COL_W)-1:0]    din,
  input  logic                     din_ones,
  output logic [COL_W+ROW_W-1:0]   acc_p,
  output logic [COL_W+ROW_W-1:0]   acc_n,
  output logic                     all_ones
);

  localparam int DW = 1 << COL_W;
  localparam int CW = COL_W + ROW_W;

  logic [COL_W-1:0] col_p, col_n;
  logic             word_par;
  logic [CW-1:0]    add_p, add_n;
  logic [CW-1:0]    p_d, n_d;
  logic             ones_d;
  logic             upd;

  // Column terms: parity of the set bits whose bit index has bit k at 1 (or at 0).
  genvar k;
  generate
    for (k = 0; k < COL_W; k++) begin : g_col
      localparam logic [DW-1:0] SEL = DW'(col_sel(k));
      assign col_p[k] = ^(din & SEL);
      assign col_n[k] = ^(din & ~SEL);
    end
  endgenerate

  // Row terms: an odd word toggles the word-index bits or their complement.
  assign word_par = ^din;
  assign add_p    = {(word_par ? idx  : {ROW_W{1'b0}}), col_p};
  assign add_n    = {(word_par ? ~idx : {ROW_W{1'b0}}), col_n};
  assign upd      = clr | en;

  always_comb begin
    p_d    = clr ? '0   : acc_p;
    n_d    = clr ? '0   : acc_n;
    ones_d = clr ? 1'b1 : all_ones;
    if (en) begin
      p_d    = p_d ^ add_p;
      n_d    = n_d ^ add_n;
      ones_d = ones_d & din_ones;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_p    <= '0;
      acc_n    <= '0;
      all_ones <= 1'b1;
    end else if (upd) begin
      acc_p    <= p_d;
      acc_n    <= n_d;
      all_ones <= ones_d;
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (acc_p == '0 && acc_n == '0 && all_ones)); // R4

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> ($stable(acc_p) && $stable(acc_n))); // R2

endmodule

// File: rtl/ecc_code_cap.sv
module ecc_code_cap #(
  parameter int DW = 16,
  parameter int SW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          wide,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] din,
  output logic [SW-1:0] code_q
);

  localparam int HW = DW / 2;
  localparam int NN = SW / HW;
  localparam int NW = SW / DW;

  logic [SW-1:0] code_d;

  always_comb begin
    code_d = clr ? '0 : code_q;
    if (en) begin
      for (int j = 0; j < NN; j++) begin
        if (!wide && idx == IW'(j)) code_d[j*HW +: HW] = din[HW-1:0];
      end
      for (int j = 0; j < NW; j++) begin
        if (wide && idx == IW'(j)) code_d[j*DW +: DW] = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clr || en) begin
      code_q <= code_d;
    end
  end

  AST_CAP_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !wide && idx == '0) |=> (code_q[HW-1:0] == $past(din[HW-1:0]))); // R3

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0]   acc_p,
  input  logic [CW-1:0]   acc_n,
  input  logic [2*CW-1:0] stored,
  input  logic            data_ones,
  output ecc_flags_t      flags,
  output logic [CW-1:0]   loc
);

  logic [CW-1:0] syn_p, syn_n;
  logic          code_ones;

  assign syn_p     = acc_p ^ stored[CW-1:0];
  assign syn_n     = acc_n ^ stored[2*CW-1:CW];
  assign code_ones = &stored;

  always_comb begin
    flags = '0;
    loc   = syn_p;
    if (data_ones && code_ones) begin
      flags.rec = 1'b1;
      flags.mul = 1'b1;
      loc       = '1;
    end else if ({syn_n, syn_p} == '0) begin
      flags = '0;
    end else if ($onehot({syn_n, syn_p})) begin
      flags.rec = 1'b1;
      flags.cod = 1'b1;
    end else if (syn_p == ~syn_n) begin
      flags.rec = 1'b1;
    end else begin
      flags.rec = 1'b1;
      flags.mul = 1'b1;
    end
  end

endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine
  import ecc_pkg::*;
#(
  parameter int BASE_BYTES = 528,
  parameter int COL_W      = 4,
  parameter int ROW_W      = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_we,
  input  logic [1:0]             mode_span,
  input  logic                   mode_wide,
  input  logic                   cmd_clr,
  input  logic                   bus_valid,
  input  logic [(1<<COL_W)-1:0]  bus_data,
  output logic [COL_W+ROW_W-1:0] par_word,
  output logic [COL_W+ROW_W-1:0] npar_word,
  output logic                   st_rec,
  output logic                   st_mul,
  output logic                   st_code,
  output logic                   chk_done
);

  localparam int DW     = 1 << COL_W;
  localparam int HW     = DW / 2;
  localparam int CW     = COL_W + ROW_W;
  localparam int SW     = 2 * CW;
  localparam int N_STRB = SW / HW;
  localparam int W_STRB = SW / DW;
  localparam int CIW    = $clog2(N_STRB);
  localparam int CNT_W  = $clog2(BASE_BYTES * 8 + 1);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // Mode register
  logic [1:0] span_q;
  logic       wide_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      span_q <= 2'd0;
      wide_q <= 1'b0;
    end else if (mode_we) begin
      span_q <= mode_span;
      wide_q <= mode_wide;
    end
  end

  logic [CNT_W-1:0] page_bytes, page_words;
  assign page_bytes = CNT_W'(BASE_BYTES) << span_q;
  assign page_words = wide_q ? (page_bytes >> 1) : page_bytes;

  // Sequencer
  ecc_state_e       state_q, state_d;
  logic [CNT_W-1:0] word_q, word_d;
  logic [CIW-1:0]   ccnt_q, ccnt_d;
  logic             clr_any, in_code, in_cmp, in_done;
  logic             new_page, take_word, take_code;
  logic             word_last, code_last;

  assign clr_any   = cmd_clr | mode_we;
  assign in_code   = (state_q == ST_CODE);
  assign in_cmp    = (state_q == ST_CMP);
  assign in_done   = (state_q == ST_DONE);
  assign take_word = bus_valid & ~clr_any & ((state_q == ST_DATA) | in_done);
  assign new_page  = bus_valid & ~clr_any & in_done;
  assign take_code = bus_valid & ~clr_any & in_code;
  assign word_last = (word_q == page_words - CNT_W'(1));
  assign code_last = wide_q ? (ccnt_q == CIW'(W_STRB - 1)) : (ccnt_q == CIW'(N_STRB - 1));

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    ccnt_d  = ccnt_q;
    if (clr_any) begin
      state_d = ST_DATA;
      word_d  = '0;
      ccnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_DATA: if (bus_valid) begin
          if (word_last) begin
            state_d = ST_CODE;
            word_d  = '0;
            ccnt_d  = '0;
          end else begin
            word_d  = word_q + CNT_W'(1);
          end
        end
        ST_CODE: if (bus_valid) begin
          if (code_last) state_d = ST_CMP;
          else           ccnt_d  = ccnt_q + CIW'(1);
        end
        ST_CMP:  state_d = ST_DONE;
        ST_DONE: if (bus_valid) begin
          state_d = ST_DATA;
          word_d  = CNT_W'(1);
          ccnt_d  = '0;
        end
        default: state_d = ST_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_DATA;
      word_q  <= '0;
      ccnt_q  <= '0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      ccnt_q  <= ccnt_d;
    end
  end

  // Datapath
  logic [DW-1:0]    data_m;
  logic             data_ones;
  logic [ROW_W-1:0] row_idx;
  logic [CW-1:0]    acc_p, acc_n;
  logic             all_ones;
  logic [SW-1:0]    code_q;

  assign data_m    = wide_q ? bus_data : {{HW{1'b0}}, bus_data[HW-1:0]};
  assign data_ones = wide_q ? (&bus_data) : (&bus_data[HW-1:0]);
  assign row_idx   = in_done ? '0 : word_q[ROW_W-1:0];

  ecc_accum #(.COL_W(COL_W), .ROW_W(ROW_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (clr_any | new_page),
    .en       (take_word),
    .idx      (row_idx),
    .din      (data_m),
    .din_ones (data_ones),
    .acc_p    (acc_p),
    .acc_n    (acc_n),
    .all_ones (all_ones)
  );

  ecc_code_cap #(.DW(DW), .SW(SW), .IW(CIW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .clr    (clr_any | new_page),
    .en     (take_code),
    .wide   (wide_q),
    .idx    (ccnt_q),
    .din    (bus_data),
    .code_q (code_q)
  );

  ecc_flags_t    cls_flags, res_flags_q, res_flags_d;
  logic [CW-1:0] cls_loc, res_loc_q, res_loc_d;

  ecc_classify #(.CW(CW)) u_cls (
    .acc_p     (acc_p),
    .acc_n     (acc_n),
    .stored    (code_q),
    .data_ones (all_ones),
    .flags     (cls_flags),
    .loc       (cls_loc)
  );

  // Result register
  always_comb begin
    res_flags_d = res_flags_q;
    res_loc_d   = res_loc_q;
    if (clr_any || new_page) begin
      res_flags_d = '0;
      res_loc_d   = '0;
    end else if (in_cmp) begin
      res_flags_d = cls_flags;
      res_loc_d   = cls_loc;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_flags_q <= '0;
      res_loc_q   <= '0;
    end else if (clr_any || new_page || in_cmp) begin
      res_flags_q <= res_flags_d;
      res_loc_q   <= res_loc_d;
    end
  end

  assign par_word  = in_done ? res_loc_q : acc_p;
  assign npar_word = acc_n;
  assign st_rec    = res_flags_q.rec;
  assign st_mul    = res_flags_q.mul;
  assign st_code   = res_flags_q.cod;
  assign chk_done  = in_done;

  // Assertions
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_i_n)
    clr_any |=> (par_word == '0 && npar_word == '0 && !chk_done && !st_rec)); // R4

  AST_WORD_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_i_n)
    word_q < page_words); // R5

  AST_CHECK_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (take_code && code_last) ##1 !clr_any |=> chk_done); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (chk_done && !bus_valid && !clr_any) |=>
      (chk_done && $stable(par_word) && $stable({st_rec, st_mul, st_code}))); // R6

  AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(st_mul && st_code)); // R10

  AST_KIND_IMPLIES_REC: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_mul || st_code) |-> st_rec); // R11

  AST_NEW_PAGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_i_n)
    new_page |=> (!chk_done && !st_rec && !st_mul && !st_code)); // R13

endmodule

// File: tb/ecc_page_engine_bench.sv
module ecc_page_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, mode_wide, cmd_clr, bus_valid;
  logic [1:0]  mode_span;
  logic [15:0] bus_data;
  logic [15:0] par_word, npar_word;
  logic        st_rec, st_mul, st_code, chk_done;

  always #10 clk = ~clk;

  ecc_page_engine u_ecc_page_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_span (mode_span),
    .mode_wide (mode_wide),
    .cmd_clr   (cmd_clr),
    .bus_valid (bus_valid),
    .bus_data  (bus_data),
    .par_word  (par_word),
    .npar_word (npar_word),
    .st_rec    (st_rec),
    .st_mul    (st_mul),
    .st_code   (st_code),
    .chk_done  (chk_done)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";

  // Reference model state
  int          m_span, m_wide, m_phase, m_idx, m_cb;
  logic [15:0] m_p, m_n, m_loc;
  logic [31:0] m_code;
  bit          m_ones, m_rec, m_mul, m_cod;

  logic [15:0] pg [0:2111];

  function automatic int m_words();
    return (528 << m_span) >> m_wide;
  endfunction

  function automatic void m_page_reset();
    m_phase = 0; m_idx = 0; m_cb = 0;
    m_p = 0; m_n = 0; m_code = 0; m_loc = 0;
    m_ones = 1; m_rec = 0; m_mul = 0; m_cod = 0;
  endfunction

  function automatic void m_acc(int w, logic [15:0] d);
    logic [15:0] dd;
    logic [15:0] a;
    dd = m_wide ? d : {8'h00, d[7:0]};
    for (int b = 0; b < 16; b++) begin
      if (dd[b]) begin
        a   = 16'(((w % 4096) * 16) + b);
        m_p = m_p ^ a;
        m_n = m_n ^ ~a;
      end
    end
    m_ones = m_ones && (m_wide ? (d == 16'hFFFF) : (d[7:0] == 8'hFF));
  endfunction

  function automatic void m_eval();
    logic [15:0] sp, sn;
    sp = m_p ^ m_code[15:0];
    sn = m_n ^ m_code[31:16];
    m_rec = 0; m_mul = 0; m_cod = 0; m_loc = sp;
    if (m_ones && m_code == 32'hFFFF_FFFF) begin
      m_rec = 1; m_mul = 1; m_loc = 16'hFFFF;
    end else if (sp == 0 && sn == 0) begin
      m_loc = 0;
    end else if ($countones({sn, sp}) == 1) begin
      m_rec = 1; m_cod = 1;
    end else if (sp == ~sn) begin
      m_rec = 1;
    end else begin
      m_rec = 1; m_mul = 1;
    end
  endfunction

  function automatic void m_edge(bit clr, bit mwe, logic [1:0] span, bit wide, bit v, logic [15:0] d);
    if (mwe) begin
      m_span = span; m_wide = wide;
    end
    if (clr || mwe) begin
      m_page_reset();
      return;
    end
    case (m_phase)
      0: if (v) begin
        m_acc(m_idx, d);
        m_idx++;
        if (m_idx == m_words()) begin
          m_phase = 1; m_idx = 0; m_cb = 0;
        end
      end
      1: if (v) begin
        if (m_wide) m_code[m_cb*16 +: 16] = d;
        else        m_code[m_cb*8 +: 8]   = d[7:0];
        m_cb++;
        if (m_cb == (m_wide ? 2 : 4)) m_phase = 2;
      end
      2: begin
        m_eval();
        m_phase = 3;
      end
      default: if (v) begin
        m_page_reset();
        m_acc(0, d);
        m_idx = 1;
      end
    endcase
  endfunction

  task automatic compare();
    logic [15:0] e_par;
    logic [2:0]  e_fl;
    bit          e_done;
    e_done = (m_phase == 3);
    e_par  = e_done ? m_loc : m_p;
    e_fl   = {m_rec, m_mul, m_cod};
    total++;
    if (par_word !== e_par || npar_word !== m_n || chk_done !== e_done ||
        {st_rec, st_mul, st_code} !== e_fl) begin
      bad++;
      $display("FAIL %s model: par=%h exp %h npar=%h exp %h flags=%b exp %b done=%b exp %b",
               cur_req, par_word, e_par, npar_word, m_n, {st_rec, st_mul, st_code}, e_fl,
               chk_done, e_done);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit clr, bit mwe, logic [1:0] span, bit wide, bit v, logic [15:0] d);
    cmd_clr   = clr;
    mode_we   = mwe;
    mode_span = span;
    mode_wide = wide;
    bus_valid = v;
    bus_data  = d;
    @(posedge clk);
    #1;
    m_edge(clr, mwe, span, wide, v, d);
    cmd_clr   = 1'b0;
    mode_we   = 1'b0;
    bus_valid = 1'b0;
    bus_data  = 16'h0;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'(m_span), m_wide[0], 0, 16'h0);
  endtask

  task automatic word(logic [15:0] d);
    cyc(0, 0, 2'(m_span), m_wide[0], 1, d);
  endtask

  task automatic set_mode(int span, bit wide);
    cyc(0, 1, 2'(span), wide, 0, 16'h0);
  endtask

  task automatic fill(int seed, int n);
    for (int i = 0; i < n; i++) pg[i] = 16'((i * 40503 + seed * 977) ^ (i >> 2));
  endtask

  task automatic calc(int n, bit wide, output logic [15:0] p, output logic [15:0] q);
    logic [15:0] a, dd;
    p = 0; q = 0;
    for (int w = 0; w < n; w++) begin
      dd = wide ? pg[w] : {8'h00, pg[w][7:0]};
      for (int b = 0; b < 16; b++) begin
        if (dd[b]) begin
          a = 16'(((w % 4096) * 16) + b);
          p = p ^ a;
          q = q ^ ~a;
        end
      end
    end
  endtask

  task automatic send_page(int from, int n);
    for (int i = from; i < n; i++) word(pg[i]);
  endtask

  task automatic send_code(logic [31:0] code, bit wide);
    if (wide) begin
      word(code[15:0]);
      word(code[31:16]);
    end else begin
      for (int j = 0; j < 4; j++) word({8'hA5, code[j*8 +: 8]});
    end
  endtask

  task automatic expect_result(string req, bit rec, bit mul, bit cod, logic [15:0] loc);
    chk(req, {29'h0, chk_done, 2'b0}, {29'h0, 1'b1, 2'b0});
    chk(req, {29'h0, st_rec, st_mul, st_code}, {29'h0, rec, mul, cod});
    chk(req, {16'h0, par_word}, {16'h0, loc});
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] p, q;
    rst_n = 1'b0; mode_we = 0; mode_span = 0; mode_wide = 0;
    cmd_clr = 0; bus_valid = 0; bus_data = 0;
    m_span = 0; m_wide = 0;
    m_page_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", {par_word, npar_word}, 32'h0);
    chk("R1", {28'h0, st_rec, st_mul, st_code, chk_done}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R2, R3: program-side code on an 8-bit page with junk in the upper byte
    cur_req = "R2";
    set_mode(0, 0);
    fill(1, 528);
    send_page(0, 528);
    calc(528, 0, p, q);
    chk("R3", {16'h0, par_word}, {16'h0, p});
    chk("R3", {16'h0, npar_word}, {16'h0, q});
    cur_req = "R4";
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4", {par_word, npar_word}, 32'h0);

    // R7, R6: clean read
    cur_req = "R7";
    send_page(0, 528);
    send_code({q, p}, 0);
    chk("R6", {31'h0, chk_done}, 32'h0);
    idle(1);
    expect_result("R7", 0, 0, 0, 16'h0);
    idle(3);
    expect_result("R6", 0, 0, 0, 16'h0);

    // R13, R8: new page from done, single data error
    cur_req = "R13";
    fill(2, 528);
    calc(528, 0, p, q);
    pg[300] = pg[300] ^ 16'h0020;
    word(pg[0]);
    chk("R13", {28'h0, st_rec, st_mul, st_code, chk_done}, 32'h0);
    cur_req = "R8";
    send_page(1, 528);
    send_code({q, p}, 0);
    idle(1);
    expect_result("R8", 1, 0, 0, 16'(300 * 16 + 5));
    cyc(1, 0, 0, 0, 0, 0);

    // R9: 16-bit bus, 1056-byte span, bit 13 flipped
    cur_req = "R9";
    set_mode(1, 1);
    fill(3, 528);
    calc(528, 1, p, q);
    pg[77] = pg[77] ^ 16'h2000;
    send_page(0, 528);
    send_code({q, p}, 1);
    idle(1);
    expect_result("R9", 1, 0, 0, 16'(77 * 16 + 13));
    cyc(1, 0, 0, 0, 0, 0);

    // R10: one flipped bit in code byte 0
    cur_req = "R10";
    set_mode(0, 0);
    fill(4, 528);
    calc(528, 0, p, q);
    send_page(0, 528);
    send_code({q, p} ^ 32'h0000_0004, 0);
    idle(1);
    expect_result("R10", 1, 0, 1, 16'h0004);
    cyc(1, 0, 0, 0, 0, 0);

    // R11: two data errors
    cur_req = "R11";
    fill(5, 528);
    calc(528, 0, p, q);
    pg[10]  = pg[10] ^ 16'h0001;
    pg[400] = pg[400] ^ 16'h0080;
    send_page(0, 528);
    send_code({q, p}, 0);
    idle(1);
    chk("R11", {29'h0, st_rec, st_mul, st_code}, 32'h6);
    cyc(1, 0, 0, 0, 0, 0);

    // R12: erased page
    cur_req = "R12";
    for (int i = 0; i < 528; i++) pg[i] = 16'(i * 16'h0100 + 16'h00FF);
    send_page(0, 528);
    send_code(32'hFFFF_FFFF, 0);
    idle(1);
    expect_result("R12", 1, 1, 0, 16'hFFFF);
    cyc(1, 0, 0, 0, 0, 0);

    // R4: mode write mid-page empties the page
    cur_req = "R4";
    fill(6, 20);
    send_page(0, 20);
    set_mode(3, 1);
    chk("R4", {par_word, npar_word}, 32'h0);

    // R5: largest span on the 16-bit bus
    cur_req = "R5";
    fill(7, 2112);
    calc(2112, 1, p, q);
    send_page(0, 2112);
    word(p);
    chk("R5", {31'h0, chk_done}, 32'h0);
    word(q);
    idle(1);
    expect_result("R5", 0, 0, 0, 16'h0);
    cyc(1, 0, 0, 0, 0, 0);

    // R5: 2112-byte span on the 8-bit bus
    set_mode(2, 0);
    fill(8, 2112);
    calc(2112, 0, p, q);
    send_page(0, 2112);
    send_code({q, p}, 0);
    idle(2);
    expect_result("R5", 0, 0, 0, 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule